// File: doc/BRIEF.md
# Interlace-Capable Raster Scan Position Counter

This block produces the horizontal and vertical scan coordinates for a raster display. Each axis runs between a programmed start coordinate and a programmed stop coordinate. A line lasts `xstop - xstart` dots and a frame lasts `ystop - ystart` lines. Two strobes and a flag go with the coordinates. One strobe marks the first dot of every line and one marks the first dot of every frame. The flag tells which vertical pair the current frame uses.

For interlaced, TV-style timing, the vertical axis has two register pairs, called odd and even, and uses them on alternate frames. The two start values are normally equal and the two stop values normally differ by one. Two consecutive frames then have different line counts, so a frame pair holds an odd number of lines. When interlace is off, only the odd pair is used.

All configuration inputs are captured into shadow registers at the first dot of each frame. A frame therefore never mixes old and new limits. The start and stop values always drive the counters, whatever produces the sync pulses further down the pipeline.

Top module: `tmg_raster_timer`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. On the first rising clock edge after `rst_n` rises, the outputs become `x_pos = cfg_xstart` and `y_pos = cfg_ystart_odd`, with `line_start = 1`, `frame_start = 1` and `field_even = 0`.
- R2: Within a line, `x_pos` rises by one on every clock. After the dot at `xstop - 1` it returns to `xstart`, so a line has `xstop - xstart` dots.
- R3: `line_start` is 1 exactly on the first dot of each line, which is a cycle where `x_pos` equals the captured `xstart`.
- R4: `y_pos` rises by one at each line start inside a frame. A frame has `ystop - ystart` lines, taken from the pair that is active for that frame.
- R5: `frame_start` is 1 exactly on the first dot of each frame, and it is always accompanied by `line_start`.
- R6: With `cfg_interlace = 1`, `field_even` toggles at every frame start. `field_even = 1` means the even pair (`cfg_ystart_even`, `cfg_ystop_even`) governs the frame; 0 means the odd pair does.
- R7: With `cfg_interlace = 0` captured, `field_even` stays 0 and the even pair has no effect on the counters.
- R8: A configuration change in the middle of a frame does not alter the current frame. It takes effect from the next frame start.
- R9: When a stop value is not above its start value, that axis has a period of one: every cycle is a line start, and with both axes degenerate every cycle is a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xstart | input | XW | First horizontal coordinate of a line |
| cfg_xstop | input | XW | Horizontal stop; the line length is stop minus start |
| cfg_ystart_odd | input | YW | First line coordinate of an odd frame |
| cfg_ystop_odd | input | YW | Vertical stop of an odd frame |
| cfg_ystart_even | input | YW | First line coordinate of an even frame |
| cfg_ystop_even | input | YW | Vertical stop of an even frame |
| cfg_interlace | input | 1 | 1 alternates the odd and even pairs; 0 uses the odd pair only |
| x_pos | output | XW | Current horizontal scan coordinate |
| y_pos | output | YW | Current vertical scan coordinate |
| line_start | output | 1 | High on the first dot of each line |
| frame_start | output | 1 | High on the first dot of each frame |
| field_even | output | 1 | 1 while the even vertical pair is active |

## Verification
Every output is registered. A configuration value therefore appears in the outputs at the first rising edge that samples it as the next frame boundary. Each coordinate step and strobe appears one edge after the dot that causes it.

The bench drives inputs on falling edges. Before each rising edge it advances an integer dot/line model using the inputs the design will sample at that edge. At the following falling edge it compares all five outputs, so expected and actual values are always from the same cycle.

Windowed counts of strobes and parity cycles are checked against frame lengths worked out from the programmed limits.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

    localparam int TMG_XW = 12;
    localparam int TMG_YW = 11;

    typedef enum logic {
        FIELD_ODD  = 1'b0,
        FIELD_EVEN = 1'b1
    } field_e;

    function automatic field_e flip_field(input field_e f);
        return (f == FIELD_ODD) ? FIELD_EVEN : FIELD_ODD;
    endfunction

endpackage

// File: rtl/tmg_axis_cnt.sv
module tmg_axis_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] start,
    input  logic [W-1:0] stop,
    output logic [W-1:0] pos,
    output logic         wrap
);
    localparam int EW = W + 1;

    typedef struct packed {
        logic [W-1:0] pos;
    } cnt_s;

    cnt_s          cnt_d, cnt_q;
    logic [EW-1:0] inc;

    assign inc  = {1'b0, cnt_q.pos} + EW'(1);
    assign wrap = step && (inc >= {1'b0, stop});
    assign pos  = cnt_q.pos;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.pos = start;
        end else if (step) begin
            cnt_d.pos = wrap ? start : inc[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2 / R4: a non-wrapping step moves the coordinate up by exactly one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap && !load) |=> (pos == W'($past(pos) + 1'b1)));

    // R2: with no step and no load the coordinate holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(pos));

endmodule

// File: rtl/tmg_frame_regs.sv
module tmg_frame_regs
    import tmg_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prime,
    input  logic          frame_end,
    input  logic [XW-1:0] cfg_xstart,
    input  logic [XW-1:0] cfg_xstop,
    input  logic [YW-1:0] cfg_ystart_odd,
    input  logic [YW-1:0] cfg_ystop_odd,
    input  logic [YW-1:0] cfg_ystart_even,
    input  logic [YW-1:0] cfg_ystop_even,
    input  logic          cfg_interlace,
    output logic [XW-1:0] sh_xstart,
    output logic [XW-1:0] sh_xstop,
    output logic [YW-1:0] act_ystop,
    output logic [YW-1:0] nxt_ystart,
    output logic          sh_interlace,
    output logic          field_even
);
    typedef struct packed {
        logic [XW-1:0] xs;
        logic [XW-1:0] xe;
        logic [YW-1:0] ye_odd;
        logic [YW-1:0] ye_even;
        logic          ilace;
        field_e        par;
    } shadow_s;

    shadow_s sh_d, sh_q;
    logic    capture;
    field_e  nxt_par;

    assign capture = prime || frame_end;

    always_comb begin
        if (prime || !cfg_interlace) begin
            nxt_par = FIELD_ODD;
        end else begin
            nxt_par = flip_field(sh_q.par);
        end
    end

    assign nxt_ystart = (nxt_par == FIELD_EVEN) ? cfg_ystart_even : cfg_ystart_odd;

    always_comb begin
        sh_d = sh_q;
        if (capture) begin
            sh_d.xs      = cfg_xstart;
            sh_d.xe      = cfg_xstop;
            sh_d.ye_odd  = cfg_ystop_odd;
            sh_d.ye_even = cfg_ystop_even;
            sh_d.ilace   = cfg_interlace;
            sh_d.par     = nxt_par;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sh_xstart    = sh_q.xs;
    assign sh_xstop     = sh_q.xe;
    assign act_ystop    = (sh_q.par == FIELD_EVEN) ? sh_q.ye_even : sh_q.ye_odd;
    assign sh_interlace = sh_q.ilace;
    assign field_even   = (sh_q.par == FIELD_EVEN);

    // R8: captured limits never move between frame boundaries
    a_r8_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(sh_q));

    // R7: a frame captured without interlace is always an odd frame
    a_r7_odd_only: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !cfg_interlace) |=> !field_even);

endmodule

// File: rtl/tmg_raster_timer.sv
module tmg_raster_timer
    import tmg_pkg::*;
#(
    parameter int XW = tmg_pkg::TMG_XW,
    parameter int YW = tmg_pkg::TMG_YW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] cfg_xstart,
    input  logic [XW-1:0] cfg_xstop,
    input  logic [YW-1:0] cfg_ystart_odd,
    input  logic [YW-1:0] cfg_ystop_odd,
    input  logic [YW-1:0] cfg_ystart_even,
    input  logic [YW-1:0] cfg_ystop_even,
    input  logic          cfg_interlace,
    output logic [XW-1:0] x_pos,
    output logic [YW-1:0] y_pos,
    output logic          line_start,
    output logic          frame_start,
    output logic          field_even
);
    typedef struct packed {
        logic prime;
        logic line;
        logic frame;
    } strobe_s;

    strobe_s       strb_d, strb_q;
    logic          x_wrap, y_wrap;
    logic [XW-1:0] sh_xstart, sh_xstop, x_start_sel;
    logic [YW-1:0] act_ystop, nxt_ystart;
    logic          sh_interlace;

    assign x_start_sel = (strb_q.prime || y_wrap) ? cfg_xstart : sh_xstart;

    tmg_frame_regs #(.XW(XW), .YW(YW)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .prime           (strb_q.prime),
        .frame_end       (y_wrap),
        .cfg_xstart      (cfg_xstart),
        .cfg_xstop       (cfg_xstop),
        .cfg_ystart_odd  (cfg_ystart_odd),
        .cfg_ystop_odd   (cfg_ystop_odd),
        .cfg_ystart_even (cfg_ystart_even),
        .cfg_ystop_even  (cfg_ystop_even),
        .cfg_interlace   (cfg_interlace),
        .sh_xstart       (sh_xstart),
        .sh_xstop        (sh_xstop),
        .act_ystop       (act_ystop),
        .nxt_ystart      (nxt_ystart),
        .sh_interlace    (sh_interlace),
        .field_even      (field_even)
    );

    tmg_axis_cnt #(.W(XW)) u_xcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strb_q.prime),
        .step  (1'b1),
        .start (x_start_sel),
        .stop  (sh_xstop),
        .pos   (x_pos),
        .wrap  (x_wrap)
    );

    tmg_axis_cnt #(.W(YW)) u_ycnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strb_q.prime),
        .step  (x_wrap),
        .start (nxt_ystart),
        .stop  (act_ystop),
        .pos   (y_pos),
        .wrap  (y_wrap)
    );

    always_comb begin
        strb_d       = strb_q;
        strb_d.prime = 1'b0;
        strb_d.line  = strb_q.prime || x_wrap;
        strb_d.frame = strb_q.prime || y_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= '{prime: 1'b1, line: 1'b0, frame: 1'b0};
        end else begin
            strb_q <= strb_d;
        end
    end

    assign line_start  = strb_q.line;
    assign frame_start = strb_q.frame;

    // R5: a frame start is always also a line start
    a_r5_frame_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);

    // R3: every line begins at the captured horizontal start
    a_r3_line_at_xstart: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (x_pos == sh_xstart));

    // R4: a line start inside a frame moves y by one
    a_r4_y_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start) |-> (y_pos == YW'($past(y_pos) + 1'b1)));

    // R6: with interlace, each new frame flips the parity
    a_r6_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && sh_interlace && !$past(strb_q.prime))
            |-> (field_even != $past(field_even)));

endmodule

// File: tb/tmg_raster_timer_test.sv
module tmg_raster_timer_test;
    localparam int XW = 12;
    localparam int YW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [XW-1:0] cfg_xstart = '0, cfg_xstop = '0;
    logic [YW-1:0] cfg_ystart_odd = '0, cfg_ystop_odd = '0;
    logic [YW-1:0] cfg_ystart_even = '0, cfg_ystop_even = '0;
    logic          cfg_interlace = 1'b0;
    logic [XW-1:0] x_pos;
    logic [YW-1:0] y_pos;
    logic          line_start, frame_start, field_even;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    bit m_prime = 1'b1;
    int m_x = 0, m_y = 0, m_ls = 0, m_fs = 0, m_ev = 0;
    int s_xs = 0, s_xe = 0, s_yeo = 0, s_yee = 0, m_ys = 0;
    int dot = 0, line = 0;

    // windowed counters
    int cnt_ls = 0, cnt_fs = 0, cnt_ev = 0;

    always #10 clk = ~clk;

    tmg_raster_timer #(.XW(XW), .YW(YW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_xstart(cfg_xstart), .cfg_xstop(cfg_xstop),
        .cfg_ystart_odd(cfg_ystart_odd), .cfg_ystop_odd(cfg_ystop_odd),
        .cfg_ystart_even(cfg_ystart_even), .cfg_ystop_even(cfg_ystop_even),
        .cfg_interlace(cfg_interlace),
        .x_pos(x_pos), .y_pos(y_pos), .line_start(line_start),
        .frame_start(frame_start), .field_even(field_even)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic int span(input int a, input int b);
        return (b > a) ? (b - a) : 1;
    endfunction

    task automatic open_frame(input int ev);
        s_xs  = int'(cfg_xstart);
        s_xe  = int'(cfg_xstop);
        s_yeo = int'(cfg_ystop_odd);
        s_yee = int'(cfg_ystop_even);
        m_ev  = ev;
        m_ys  = ev ? int'(cfg_ystart_even) : int'(cfg_ystart_odd);
        dot   = 0;
        line  = 0;
        m_fs  = 1;
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_prime = 1'b1;
            m_x = 0; m_y = 0; m_ls = 0; m_fs = 0; m_ev = 0;
            return;
        end
        if (m_prime) begin
            m_prime = 1'b0;
            open_frame(0);
        end else begin
            m_fs = 0;
            dot++;
            if (dot >= span(s_xs, s_xe)) begin
                dot = 0;
                line++;
                if (line >= span(m_ys, m_ev ? s_yee : s_yeo)) begin
                    open_frame(cfg_interlace ? (1 - m_ev) : 0);
                end
            end
        end
        m_ls = (dot == 0);
        m_x  = s_xs + dot;
        m_y  = m_ys + line;
    endtask

    task automatic compare();
        check(int'(x_pos) == m_x, "R2 x_pos", int'(x_pos), m_x);
        check(int'(y_pos) == m_y, "R4 y_pos", int'(y_pos), m_y);
        check(int'(line_start) == m_ls, "R3 line_start", int'(line_start), m_ls);
        check(int'(frame_start) == m_fs, "R5 frame_start", int'(frame_start), m_fs);
        check(int'(field_even) == m_ev, "R6 field_even", int'(field_even), m_ev);
        cnt_ls += int'(line_start);
        cnt_fs += int'(frame_start);
        cnt_ev += int'(field_even);
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic clear_counts();
        cnt_ls = 0; cnt_fs = 0; cnt_ev = 0;
    endtask

    initial begin
        @(negedge clk);
        cfg_xstart = 12'd3;  cfg_xstop = 12'd13;
        cfg_ystart_odd = 11'd2;  cfg_ystop_odd = 11'd7;
        cfg_ystart_even = 11'd2; cfg_ystop_even = 11'd8;
        cfg_interlace = 1'b1;
        tick(2);
        // R1: reset values
        check(x_pos == 0 && y_pos == 0, "R1 reset coords", int'(x_pos) + int'(y_pos), 0);
        check(!line_start && !frame_start && !field_even, "R1 reset flags",
              int'({line_start, frame_start, field_even}), 0);

        rst_n = 1'b1;
        tick();
        // R1: first frame after release
        check(x_pos == 3, "R1 first x", int'(x_pos), 3);
        check(y_pos == 2, "R1 first y", int'(y_pos), 2);
        check(line_start && frame_start && !field_even, "R1 first strobes",
              int'({line_start, frame_start, field_even}), 6);

        // R4/R6: interlaced frame pair, 5 + 6 lines of 10 dots
        clear_counts();
        tick(110);
        check(cnt_ls == 11, "R4 lines per frame pair", cnt_ls, 11);
        check(cnt_fs == 2, "R5 frame starts per pair", cnt_fs, 2);
        check(cnt_ev == 60, "R6 even-frame cycles", cnt_ev, 60);
        check(frame_start && !field_even, "R6 back to odd", int'({frame_start, field_even}), 2);

        // R8: mid-frame change must not cut the running frame short
        tick(3);
        cfg_xstop = 12'd9;
        cfg_ystop_odd = 11'd5;
        clear_counts();
        tick(47);
        check(cnt_fs == 1 && frame_start, "R8 old frame kept", cnt_fs, 1);
        check(field_even, "R6 even after odd", int'(field_even), 1);

        // R7: interlace off, odd pair only, even pair ignored
        cfg_interlace = 1'b0;
        cfg_ystop_even = 11'd40;
        tick(40);
        clear_counts();
        tick(100);
        check(cnt_ev == 0, "R7 no even frames", cnt_ev, 0);
        check(cnt_fs == 100 / 18 || cnt_fs == 100 / 18 + 1, "R7 odd frame length",
              cnt_fs, 100 / 18);

        // R9: degenerate limits give one-cycle lines and frames
        cfg_xstop = 12'd3;
        cfg_ystop_odd = 11'd2;
        tick(30);
        clear_counts();
        tick(20);
        check(cnt_ls == 20, "R9 line every cycle", cnt_ls, 20);
        check(cnt_fs == 20, "R9 frame every cycle", cnt_fs, 20);

        // R1: reset in the middle of operation
        cfg_xstop = 12'd13;
        cfg_ystop_odd = 11'd7;
        cfg_interlace = 1'b1;
        tick(5);
        rst_n = 1'b0;
        #1;
        check(x_pos == 0 && !line_start, "R1 async clear", int'(x_pos), 0);
        tick(2);
        rst_n = 1'b1;
        tick();
        check(x_pos == 3 && y_pos == 2 && frame_start, "R1 restart", int'(x_pos), 3);
        tick(120);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule